// File: doc/BRIEF.md
# ModRM Operand Locator

This block sits after opcode lookup in an instruction decoder. Each instruction has up to three operand slots, and each slot carries an operand-kind code and a size code. The block takes these codes, together with the prefix state and the ModRM byte, and works out where every operand lives: the execution unit class, the register number, or a flag that the operand is in memory. It also adds up how many immediate bytes follow the instruction. It flags combinations that cannot be encoded, and it gives the table row that selects between prefix variants for the three-byte-opcode rows F0–FF.

All inputs are sampled when `start_i` is high. The results appear on registered outputs after that clock edge and hold until the next start. If any rule fails, the illegal flag is raised and every other output is forced to zero. Address arithmetic, SIB and displacement fetch, and the opcode tables themselves belong to other blocks.

Top module: `modrm_operand_locator`

## Requirements
- R1: The outputs are zero during reset. A `start_i` seen at a rising edge loads the outputs at that edge. While `start_i` is low, the outputs keep their value whatever the other inputs do.
- R2: Modrm-using kinds are GPR-modrm (2), GPR-reg-only (3), memory-only (4), SSE-modrm (6), SSE-reg-only (7), MMX-modrm (9) and MMX-reg-only (10). For these, ModRM bits 7:6 = 11 selects a register, and the memory bit is 0. Any other mod value sets the memory bit and gives register number 0. The register case with `pfx_lock_i` set is illegal.
- R3: Reg-field kinds take the number {rex_r, ModRM[5:3]}. These kinds are GPR (1), SSE (5), MMX (8), segment (13), control (14) and debug (15). Register forms of the modrm kinds take {rex_b, ModRM[2:0]}. The exception is kinds 9 and 10, which take {0, ModRM[2:0]}.
- R4: Kinds 3, 7 and 10 with mod ≠ 11 are illegal. Kind 4 with mod = 11 is illegal.
- R5: Special code 1 marks an instruction that has an MMX form. With special code 1 and none of the 66/F2/F3 prefixes, kinds 5, 6 and 7 go to the MMX unit, and size codes 5 and 7 give size 3 (64-bit).
- R6: Kind 11 with VEX present is an SSE operand numbered by `vex_vvvv_i`. Without VEX, slot 0 takes the kind of slot 1, and the other slots take the kind of slot 0. A fallback that is again kind 11 gives an empty operand.
- R7: `row_o` is 2 when F3 is present. Otherwise it is 3 when F2 is present, plus 1 when 66 is present.
- R8: `imm_bytes_o` adds 1<<size for every slot of kind 12. It adds 1 more when `imm8_tail_i` is set.
- R9: Size codes map to output sizes as follows: 1→0, 2→1, 3→2, 4→3, 5 (128-bit only)→4, 6 (256-bit only)→5, 7 (128 or 256)→VEX.L?5:4. Code 6 without VEX.L is illegal. Code 5 with VEX.L is illegal unless some slot has size code 6. Empty slots give size 0 and are not checked.
- R10: Special code 2 forces slot 0 to size 2, and special code 3 forces slot 2 to size 2. This applies only when that slot is a GPR operand and not in memory.
- R11: When an instruction is illegal, `illegal_o` is 1 and every other output is 0.
- R12: Unit codes are: GPR 1 (kinds 1–3), segment 2 (kind 13), control 3 (kind 14), debug 4 (kind 15), MMX 5 (kinds 8–10), SSE 6 (kinds 5–7 and 11), and immediate 7 (kind 12). Kinds 0 and 4 give unit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sample inputs and load outputs |
| kinds_i | input | 12 | Operand-kind code, 4 bits per slot, slot 0 in the low bits |
| sizes_i | input | 9 | Size code, 3 bits per slot |
| imm8_tail_i | input | 1 | A trailing 1-byte immediate operand is present |
| special_i | input | 2 | 0 none, 1 MMX form, 2 zero-extend slot 0, 3 zero-extend slot 2 |
| pfx_data_i | input | 1 | 66 prefix seen |
| pfx_rep_i | input | 1 | F3 prefix seen |
| pfx_repne_i | input | 1 | F2 prefix seen |
| pfx_lock_i | input | 1 | Lock prefix seen |
| vex_i | input | 1 | VEX prefix present |
| vex_l_i | input | 1 | VEX.L bit |
| vex_vvvv_i | input | 4 | Decoded (non-inverted) vvvv register |
| rex_r_i | input | 1 | REX.R extension |
| rex_b_i | input | 1 | REX.B extension |
| modrm_i | input | 8 | ModRM byte |
| unit_o | output | 9 | Unit class, 3 bits per slot |
| reg_o | output | 12 | Register number, 4 bits per slot |
| mem_o | output | 3 | Memory-reference bit per slot |
| size_o | output | 9 | log2 of operand bytes, 3 bits per slot |
| imm_bytes_o | output | 7 | Immediate bytes following |
| row_o | output | 3 | Prefix row for 0F38 F0–FF |
| illegal_o | output | 1 | Illegal combination |

## Verification
A wrong fallback kind or a wrong MMX rewrite shows up as the wrong unit code or register number on the slot involved. It appears in the output word one cycle after the start strobe. A lost legality rule has a different effect: a slot that should have been zeroed still shows a register or memory bit, with `illegal_o` low. A corrupted size decision shows both in `size_o` and, for immediate slots, in `imm_bytes_o`. A broken hold path shows up as outputs that drift while `start_i` is low.

// File: rtl/mol_pkg.sv
package mol_pkg;
  parameter int NSLOT      = 3;
  parameter int KIND_W     = 4;
  parameter int SZC_W      = 3;
  parameter int UNIT_W     = 3;
  parameter int REG_W      = 4;
  parameter int LSZ_W      = 3;
  parameter int IMM_W      = 7;
  localparam int SLOT_IMM_W = (1 << LSZ_W) - 2;

  typedef enum logic [KIND_W-1:0] {
    K_NONE, K_GREG, K_GMOD, K_GRO, K_MEM, K_SREG, K_SMOD, K_SRO,
    K_MREG, K_MMOD, K_MRO, K_VVVV, K_IMM, K_SEG, K_CTL, K_DBG
  } kind_e;

  typedef enum logic [UNIT_W-1:0] {
    U_NONE, U_GPR, U_SEG, U_CTL, U_DBG, U_MMX, U_SSE, U_IMM
  } unit_e;

  typedef enum logic [SZC_W-1:0] {
    Z_NONE, Z_B, Z_W, Z_D, Z_Q, Z_DQ, Z_QQ, Z_X
  } szc_e;

  typedef enum logic [1:0] {SP_NONE, SP_MMX, SP_ZX0, SP_ZX2} spec_e;

  typedef struct packed {
    logic             ok;
    logic [LSZ_W-1:0] lsz;
  } lsz_t;

  // size code -> log2 bytes, with VEX.L legality
  function automatic lsz_t size_of(szc_e c, logic mmx, logic vl, logic qq);
    lsz_t r;
    r.ok  = 1'b1;
    r.lsz = '0;
    case (c)
      Z_B: r.lsz = LSZ_W'(0);
      Z_W: r.lsz = LSZ_W'(1);
      Z_D: r.lsz = LSZ_W'(2);
      Z_Q: r.lsz = LSZ_W'(3);
      Z_DQ: begin
        if (mmx)            r.lsz = LSZ_W'(3);
        else if (vl && !qq) r.ok  = 1'b0;
        else                r.lsz = LSZ_W'(4);
      end
      Z_QQ: begin
        if (!vl) r.ok  = 1'b0;
        else     r.lsz = LSZ_W'(5);
      end
      Z_X: r.lsz = mmx ? LSZ_W'(3) : (vl ? LSZ_W'(5) : LSZ_W'(4));
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [2:0] row_of(logic d, logic r, logic rn);
    logic [2:0] v;
    if (r) v = 3'd2;
    else   v = (rn ? 3'd3 : 3'd0) + (d ? 3'd1 : 3'd0);
    return v;
  endfunction

  function automatic logic [SLOT_IMM_W-1:0] imm_len(logic [LSZ_W-1:0] lsz);
    return SLOT_IMM_W'(1) << lsz;
  endfunction
endpackage

// File: rtl/mol_prefix_row.sv
module mol_prefix_row
  import mol_pkg::*;
(
  input  logic       data_i,
  input  logic       rep_i,
  input  logic       repne_i,
  output logic [2:0] row_o
);
  assign row_o = row_of(data_i, rep_i, repne_i);
endmodule

// File: rtl/mol_slot.sv
module mol_slot
  import mol_pkg::*;
(
  input  kind_e                  kind_i,
  input  kind_e                  alt_i,
  input  szc_e                   szc_i,
  input  logic                   mmx_i,
  input  logic                   vex_i,
  input  logic                   vex_l_i,
  input  logic [REG_W-1:0]       vvvv_i,
  input  logic                   rex_r_i,
  input  logic                   rex_b_i,
  input  logic                   lock_i,
  input  logic                   qq_any_i,
  input  logic                   zext_i,
  input  logic [7:0]             modrm_i,
  output unit_e                  unit_o,
  output logic [REG_W-1:0]       reg_o,
  output logic                   mem_o,
  output logic [LSZ_W-1:0]       lsz_o,
  output logic [SLOT_IMM_W-1:0]  imm_o,
  output logic                   bad_o
);
  logic  reg_mode, use_rm, reg_only, mem_only, rm_ext;
  kind_e k;
  lsz_t  sz;

  always_comb begin
    reg_mode = (modrm_i[7:6] == 2'b11);
    k = kind_i;
    if (k == K_VVVV && !vex_i) k = alt_i;
    if (k == K_VVVV && !vex_i) k = K_NONE;

    unit_o   = U_NONE;
    reg_o    = '0;
    mem_o    = 1'b0;
    bad_o    = 1'b0;
    use_rm   = 1'b0;
    reg_only = 1'b0;
    mem_only = 1'b0;
    rm_ext   = rex_b_i && !(k == K_MMOD || k == K_MRO);

    case (k)
      K_GREG, K_GMOD, K_GRO:   unit_o = U_GPR;
      K_SREG, K_SMOD, K_SRO:   unit_o = mmx_i ? U_MMX : U_SSE;
      K_MREG, K_MMOD, K_MRO:   unit_o = U_MMX;
      K_VVVV:                  unit_o = U_SSE;
      K_IMM:                   unit_o = U_IMM;
      K_SEG:                   unit_o = U_SEG;
      K_CTL:                   unit_o = U_CTL;
      K_DBG:                   unit_o = U_DBG;
      default:                 unit_o = U_NONE;
    endcase

    case (k)
      K_GREG, K_SREG, K_MREG, K_SEG, K_CTL, K_DBG:
        reg_o = REG_W'({rex_r_i, modrm_i[5:3]});
      K_VVVV:
        reg_o = vvvv_i;
      K_GMOD, K_SMOD, K_MMOD:
        use_rm = 1'b1;
      K_GRO, K_SRO, K_MRO: begin
        use_rm   = 1'b1;
        reg_only = 1'b1;
      end
      K_MEM: begin
        use_rm   = 1'b1;
        mem_only = 1'b1;
      end
      default: ;
    endcase

    if (use_rm) begin
      if (reg_mode) begin
        if (lock_i || mem_only) bad_o = 1'b1;
        reg_o = REG_W'({rm_ext, modrm_i[2:0]});
      end else begin
        if (reg_only) bad_o = 1'b1;
        mem_o = 1'b1;
      end
    end

    if (k == K_NONE) begin
      sz.ok  = 1'b1;
      sz.lsz = '0;
    end else begin
      sz = size_of(szc_i, mmx_i, vex_l_i, qq_any_i);
    end
    if (!sz.ok) bad_o = 1'b1;

    lsz_o = sz.lsz;
    if (zext_i && !mem_o && unit_o == U_GPR) lsz_o = LSZ_W'(2);

    imm_o = (k == K_IMM) ? imm_len(lsz_o) : '0;
  end
endmodule

// File: rtl/modrm_operand_locator.sv
module modrm_operand_locator
  import mol_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [NSLOT*KIND_W-1:0] kinds_i,
  input  logic [NSLOT*SZC_W-1:0]  sizes_i,
  input  logic                    imm8_tail_i,
  input  logic [1:0]              special_i,
  input  logic                    pfx_data_i,
  input  logic                    pfx_rep_i,
  input  logic                    pfx_repne_i,
  input  logic                    pfx_lock_i,
  input  logic                    vex_i,
  input  logic                    vex_l_i,
  input  logic [REG_W-1:0]        vex_vvvv_i,
  input  logic                    rex_r_i,
  input  logic                    rex_b_i,
  input  logic [7:0]              modrm_i,
  output logic [NSLOT*UNIT_W-1:0] unit_o,
  output logic [NSLOT*REG_W-1:0]  reg_o,
  output logic [NSLOT-1:0]        mem_o,
  output logic [NSLOT*LSZ_W-1:0]  size_o,
  output logic [IMM_W-1:0]        imm_bytes_o,
  output logic [2:0]              row_o,
  output logic                    illegal_o
);
  spec_e spec;
  logic  mmx_route;
  logic  qq_any;
  logic  ill_n;
  logic  capture_ev;
  logic [IMM_W-1:0] imm_n;
  logic [2:0]       row_n;

  unit_e                 s_unit [NSLOT];
  logic [REG_W-1:0]      s_reg  [NSLOT];
  logic                  s_mem  [NSLOT];
  logic [LSZ_W-1:0]      s_lsz  [NSLOT];
  logic [SLOT_IMM_W-1:0] s_imm  [NSLOT];
  logic                  s_bad  [NSLOT];

  assign spec       = spec_e'(special_i);
  assign mmx_route  = (spec == SP_MMX) && !(pfx_data_i || pfx_rep_i || pfx_repne_i);
  assign capture_ev = start_i;

  always_comb begin
    qq_any = 1'b0;
    for (int i = 0; i < NSLOT; i++)
      if (szc_e'(sizes_i[i*SZC_W +: SZC_W]) == Z_QQ) qq_any = 1'b1;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam int ALT = (g == 0) ? 1 : 0;
    logic zext_here;
    assign zext_here = (g == 0 && spec == SP_ZX0) || (g == 2 && spec == SP_ZX2);

    mol_slot u_slot (
      .kind_i   (kind_e'(kinds_i[g*KIND_W +: KIND_W])),
      .alt_i    (kind_e'(kinds_i[ALT*KIND_W +: KIND_W])),
      .szc_i    (szc_e'(sizes_i[g*SZC_W +: SZC_W])),
      .mmx_i    (mmx_route),
      .vex_i    (vex_i),
      .vex_l_i  (vex_l_i),
      .vvvv_i   (vex_vvvv_i),
      .rex_r_i  (rex_r_i),
      .rex_b_i  (rex_b_i),
      .lock_i   (pfx_lock_i),
      .qq_any_i (qq_any),
      .zext_i   (zext_here),
      .modrm_i  (modrm_i),
      .unit_o   (s_unit[g]),
      .reg_o    (s_reg[g]),
      .mem_o    (s_mem[g]),
      .lsz_o    (s_lsz[g]),
      .imm_o    (s_imm[g]),
      .bad_o    (s_bad[g])
    );
  end

  mol_prefix_row u_row (
    .data_i  (pfx_data_i),
    .rep_i   (pfx_rep_i),
    .repne_i (pfx_repne_i),
    .row_o   (row_n)
  );

  always_comb begin
    ill_n = 1'b0;
    imm_n = IMM_W'(imm8_tail_i);
    for (int i = 0; i < NSLOT; i++) begin
      ill_n = ill_n | s_bad[i];
      imm_n = imm_n + IMM_W'(s_imm[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_o      <= '0;
      reg_o       <= '0;
      mem_o       <= '0;
      size_o      <= '0;
      imm_bytes_o <= '0;
      row_o       <= '0;
      illegal_o   <= 1'b0;
    end else if (capture_ev) begin
      if (ill_n) begin
        unit_o      <= '0;
        reg_o       <= '0;
        mem_o       <= '0;
        size_o      <= '0;
        imm_bytes_o <= '0;
        row_o       <= '0;
        illegal_o   <= 1'b1;
      end else begin
        for (int i = 0; i < NSLOT; i++) begin
          unit_o[i*UNIT_W +: UNIT_W] <= s_unit[i];
          reg_o[i*REG_W +: REG_W]    <= s_reg[i];
          mem_o[i]                   <= s_mem[i];
          size_o[i*LSZ_W +: LSZ_W]   <= s_lsz[i];
        end
        imm_bytes_o <= imm_n;
        row_o       <= row_n;
        illegal_o   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mol_checker.sv
module mol_checker
  import mol_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic [NSLOT*KIND_W-1:0] kinds_i,
  input logic [NSLOT*SZC_W-1:0]  sizes_i,
  input logic                    pfx_rep_i,
  input logic                    pfx_lock_i,
  input logic                    vex_l_i,
  input logic [7:0]              modrm_i,
  input logic [NSLOT*UNIT_W-1:0] unit_o,
  input logic [NSLOT*REG_W-1:0]  reg_o,
  input logic [NSLOT-1:0]        mem_o,
  input logic [NSLOT*LSZ_W-1:0]  size_o,
  input logic [IMM_W-1:0]        imm_bytes_o,
  input logic [2:0]              row_o,
  input logic                    illegal_o
);
  logic  rmode;
  kind_e k0;
  szc_e  z0;
  assign rmode = (modrm_i[7:6] == 2'b11);
  assign k0    = kind_e'(kinds_i[KIND_W-1:0]);
  assign z0    = szc_e'(sizes_i[SZC_W-1:0]);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable({unit_o, reg_o, mem_o, size_o, imm_bytes_o, row_o, illegal_o}));

  p_lock_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && pfx_lock_i && rmode && k0 == K_GMOD) |=> illegal_o);

  p_regmode_nomem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && rmode) |=> (mem_o == '0));

  p_memonly_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && rmode && k0 == K_MEM) |=> illegal_o);

  p_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && pfx_rep_i) |=> (illegal_o || row_o == 3'd2));

  p_qq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !vex_l_i && z0 == Z_QQ && k0 != K_NONE && k0 != K_VVVV) |=> illegal_o);

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (unit_o == '0 && reg_o == '0 && mem_o == '0 &&
                   size_o == '0 && imm_bytes_o == '0 && row_o == '0));
endmodule

bind modrm_operand_locator mol_checker chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .kinds_i(kinds_i), .sizes_i(sizes_i),
  .pfx_rep_i(pfx_rep_i), .pfx_lock_i(pfx_lock_i), .vex_l_i(vex_l_i), .modrm_i(modrm_i),
  .unit_o(unit_o), .reg_o(reg_o), .mem_o(mem_o), .size_o(size_o),
  .imm_bytes_o(imm_bytes_o), .row_o(row_o), .illegal_o(illegal_o)
);

// File: tb/modrm_operand_locator_tb_top.sv
module modrm_operand_locator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] kinds;
  logic [8:0]  sizes;
  logic        tail;
  logic [1:0]  spec;
  logic        pd, pr, prn, pl, vx, vl, rr, rb;
  logic [3:0]  vvvv;
  logic [7:0]  modrm;
  logic [8:0]  unit_o;
  logic [11:0] reg_o;
  logic [2:0]  mem_o;
  logic [8:0]  size_o;
  logic [6:0]  imm_o;
  logic [2:0]  row_o;
  logic        ill_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  int e_unit[3], e_reg[3], e_mem[3], e_sz[3];
  int e_imm, e_row, e_ill;

  always #10ns clk = ~clk;

  modrm_operand_locator dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .kinds_i(kinds), .sizes_i(sizes),
    .imm8_tail_i(tail), .special_i(spec), .pfx_data_i(pd), .pfx_rep_i(pr),
    .pfx_repne_i(prn), .pfx_lock_i(pl), .vex_i(vx), .vex_l_i(vl),
    .vex_vvvv_i(vvvv), .rex_r_i(rr), .rex_b_i(rb), .modrm_i(modrm),
    .unit_o(unit_o), .reg_o(reg_o), .mem_o(mem_o), .size_o(size_o),
    .imm_bytes_o(imm_o), .row_o(row_o), .illegal_o(ill_o)
  );

  task automatic cmp(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int kind_at(int s);
    return int'(kinds[s*4 +: 4]);
  endfunction

  // independent model of the requirements
  task automatic predict();
    bit mmx, qq, bad, rmode;
    int k, sc, u, rg, m, sz;
    mmx   = (spec == 2'd1) && !pd && !pr && !prn;
    qq    = 0;
    for (int s = 0; s < 3; s++) if (sizes[s*3 +: 3] == 3'd6) qq = 1;
    rmode = (modrm[7:6] == 2'b11);
    bad   = 0;
    e_imm = tail;
    for (int s = 0; s < 3; s++) begin
      k = kind_at(s);
      if (k == 11 && !vx) begin
        k = (s == 0) ? kind_at(1) : kind_at(0);
        if (k == 11) k = 0;
      end
      sc = int'(sizes[s*3 +: 3]);
      u = 0; rg = 0; m = 0; sz = 0;
      if (k != 0) begin
        case (sc)
          1: sz = 0;  2: sz = 1;  3: sz = 2;  4: sz = 3;
          5: if (mmx) sz = 3; else if (vl && !qq) bad = 1; else sz = 4;
          6: if (!vl) bad = 1; else sz = 5;
          7: sz = mmx ? 3 : (vl ? 5 : 4);
          default: sz = 0;
        endcase
      end
      if (k >= 1 && k <= 3) u = 1;
      else if (k >= 5 && k <= 7) u = mmx ? 5 : 6;
      else if (k >= 8 && k <= 10) u = 5;
      else if (k == 11) u = 6;
      else if (k == 12) u = 7;
      else if (k == 13) u = 2;
      else if (k == 14) u = 3;
      else if (k == 15) u = 4;
      if (k == 1 || k == 5 || k == 8 || k >= 13) rg = 8*rr + modrm[5:3];
      if (k == 11) rg = vvvv;
      if (k == 2 || k == 3 || k == 4 || k == 6 || k == 7 || k == 9 || k == 10) begin
        if (rmode) begin
          if (pl || k == 4) bad = 1;
          rg = ((k == 9 || k == 10) ? 0 : 8*rb) + modrm[2:0];
        end else begin
          if (k == 3 || k == 7 || k == 10) bad = 1;
          m = 1;
        end
      end
      if (((s == 0 && spec == 2'd2) || (s == 2 && spec == 2'd3)) && m == 0 && u == 1) sz = 2;
      if (k == 12) e_imm += (1 << sz);
      e_unit[s] = u; e_reg[s] = rg; e_mem[s] = m; e_sz[s] = sz;
    end
    e_row = pr ? 2 : ((prn ? 3 : 0) + (pd ? 1 : 0));
    e_ill = bad;
    if (bad) begin
      for (int s = 0; s < 3; s++) begin
        e_unit[s] = 0; e_reg[s] = 0; e_mem[s] = 0; e_sz[s] = 0;
      end
      e_imm = 0; e_row = 0;
    end
  endtask

  task automatic compare(string tag);
    for (int s = 0; s < 3; s++) begin
      cmp(tag, $sformatf("R12 unit%0d", s), int'(unit_o[s*3 +: 3]), e_unit[s]);
      cmp(tag, $sformatf("R3 reg%0d", s),   int'(reg_o[s*4 +: 4]),  e_reg[s]);
      cmp(tag, $sformatf("R2 mem%0d", s),   int'(mem_o[s]),         e_mem[s]);
      cmp(tag, $sformatf("R9 size%0d", s),  int'(size_o[s*3 +: 3]), e_sz[s]);
    end
    cmp(tag, "R8 imm",     int'(imm_o), e_imm);
    cmp(tag, "R7 row",     int'(row_o), e_row);
    cmp(tag, "R11 illegal", int'(ill_o), e_ill);
  endtask

  task automatic clear_in();
    kinds = '0; sizes = '0; tail = 0; spec = 0;
    pd = 0; pr = 0; prn = 0; pl = 0; vx = 0; vl = 0; rr = 0; rb = 0;
    vvvv = '0; modrm = '0;
  endtask

  // called just after a falling edge
  task automatic apply(string tag);
    predict();
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    compare(tag);
  endtask

  function automatic logic [11:0] kk(int a, int b, int c);
    return {4'(c), 4'(b), 4'(a)};
  endfunction
  function automatic logic [8:0] zz(int a, int b, int c);
    return {3'(c), 3'(b), 3'(a)};
  endfunction

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f3a_5c07));
    clear_in();
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp("R1", "reset outputs", int'({unit_o, reg_o, mem_o, size_o, imm_o, row_o, ill_o} != 0), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: GPR modrm in register form, then with lock
    clear_in(); kinds = kk(1, 2, 0); sizes = zz(3, 3, 0); modrm = 8'hD9; apply("R2 reg form");
    pl = 1; apply("R2 lock with register");
    clear_in(); kinds = kk(2, 1, 0); sizes = zz(4, 4, 0); modrm = 8'h45; pl = 1; apply("R2 memory form");
    // R3: extension bits
    clear_in(); kinds = kk(1, 2, 0); sizes = zz(3, 3, 0); modrm = 8'hFE; rr = 1; rb = 1; apply("R3 rex both");
    clear_in(); kinds = kk(8, 9, 0); sizes = zz(4, 4, 0); modrm = 8'hC7; rr = 1; rb = 1; apply("R3 mmx no rex.b");
    // R4: register-only and memory-only
    clear_in(); kinds = kk(3, 0, 0); sizes = zz(3, 0, 0); modrm = 8'h05; apply("R4 reg-only in memory");
    clear_in(); kinds = kk(1, 4, 0); sizes = zz(3, 3, 0); modrm = 8'hC1; apply("R4 mem-only in register");
    // R5: MMX rewrite
    clear_in(); kinds = kk(5, 6, 0); sizes = zz(7, 7, 0); spec = 1; modrm = 8'hCA; rb = 1; apply("R5 mmx form");
    pd = 1; apply("R5 with 66");
    // R6: vvvv operand
    clear_in(); kinds = kk(5, 11, 6); sizes = zz(7, 7, 7); vx = 1; vvvv = 4'hB; modrm = 8'hD3; apply("R6 vex");
    clear_in(); kinds = kk(11, 6, 0); sizes = zz(5, 5, 0); modrm = 8'hE2; apply("R6 fallback slot0");
    clear_in(); kinds = kk(11, 11, 0); sizes = zz(5, 5, 0); apply("R6 double fallback");
    // R7: prefix row
    clear_in(); pr = 1; pd = 1; prn = 1; apply("R7 f3 wins");
    clear_in(); prn = 1; pd = 1; apply("R7 f2 plus 66");
    // R8: immediates
    clear_in(); kinds = kk(1, 12, 12); sizes = zz(3, 3, 1); tail = 1; modrm = 8'hC0; apply("R8 imm sum");
    // R9: VEX.L legality
    clear_in(); kinds = kk(5, 6, 0); sizes = zz(6, 6, 0); vx = 1; modrm = 8'hC0; apply("R9 256 without L");
    clear_in(); kinds = kk(5, 6, 0); sizes = zz(6, 5, 0); vx = 1; vl = 1; modrm = 8'hC0; apply("R9 128 with 256 peer");
    clear_in(); kinds = kk(5, 6, 0); sizes = zz(5, 5, 0); vx = 1; vl = 1; modrm = 8'hC0; apply("R9 128 with L");
    // R10: zero-extend
    clear_in(); kinds = kk(2, 5, 0); sizes = zz(4, 5, 0); spec = 2; modrm = 8'hC3; apply("R10 zext reg");
    modrm = 8'h03; apply("R10 zext memory");
    clear_in(); kinds = kk(5, 5, 3); sizes = zz(5, 5, 1); spec = 3; modrm = 8'hC3; apply("R10 zext slot2");
    // R12 units
    clear_in(); kinds = kk(13, 14, 15); sizes = zz(2, 4, 4); modrm = 8'h28; rr = 1; apply("R12 seg ctl dbg");

    // R1 hold: outputs stay while start is low and inputs change
    clear_in(); kinds = kk(1, 2, 12); sizes = zz(3, 3, 1); modrm = 8'hCD; apply("R1 load");
    for (int i = 0; i < 3; i++) begin
      kinds = 12'($urandom); modrm = 8'($urandom); pl = 1; pr = 1;
      @(posedge clk);
      @(negedge clk);
      compare("R1 hold");
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      clear_in();
      kinds = 12'($urandom); sizes = 9'($urandom); tail = 1'($urandom);
      spec = 2'($urandom); pd = 1'($urandom); pr = ($urandom % 4 == 0);
      prn = ($urandom % 4 == 0); pl = ($urandom % 8 == 0); vx = 1'($urandom);
      vl = 1'($urandom); vvvv = 4'($urandom); rr = 1'($urandom); rb = 1'($urandom);
      modrm = 8'($urandom);
      apply("random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule